// File: doc/BRIEF.md
# Descriptor Completion Notifier

This unit sits at the tail of a crypto channel's descriptor pipeline and decides how the host learns that a descriptor has finished. When a header is decoded, it captures the data-flow direction, the descriptor type, the host-supplied identification tag from the fetch request and the two unit-select fields. It also checks the primary unit-select field. An illegal selection latches a header error, gives an error interrupt pulse and freezes the channel until reset.

When the execution units report completion, the header's done-request bit is combined with the channel's notification enable. The result is then routed to an interrupt pulse, a single 64-bit header writeback, or both, according to two further channel enables. The writeback word carries an all-ones done byte, the copied tag and the integrity-check codes of the primary and secondary units. The write goes out over a valid/ready handshake to an external bus master.

Top module: `cn_notify_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first header, `wb_valid`, `done_irq`, `err_irq`, `hdr_err`, `seq_dir` and `seq_type` are all 0.
- R2: A `hdr_valid` accepted while idle makes `seq_dir` (0 outbound, 1 inbound) and `seq_type` show the header's direction and type from the next cycle on, and they hold until the next accepted header.
- R3: A primary unit select of 0 (no unit) or greater than `NUM_UNITS` (reserved) sets `hdr_err` from the next cycle until reset and gives a one-cycle `err_irq` pulse in that same cycle. After that no writeback or done interrupt is produced and later headers and completions are ignored.
- R4: A completion whose header done-request bit is 0, or that arrives while `cfg_notify_en` is 0, produces neither a writeback nor a done interrupt.
- R5: A notified completion with `cfg_wb_en` set raises `wb_valid` in the next cycle. `wb_valid` and `wb_data` hold until the cycle in which `wb_ready` is high.
- R6: The writeback word holds 0xFF in bits 63:56, the fetch tag captured at header decode in bits 55:48, the primary integrity code in bits 47:46, the secondary code in bits 45:44 and zeros in bits 43:0.
- R7: Integrity codes pass through unchanged (00 no comparison, 01 passed, 10 failed, 11 reserved). When the header's secondary unit select is 0, bits 45:44 are forced to 00.
- R8: With both `cfg_wb_en` and `cfg_irq_en` set, `done_irq` is a one-cycle pulse in the cycle after the write is accepted.
- R9: With `cfg_irq_en` set and `cfg_wb_en` clear, `done_irq` pulses for one cycle in the cycle after the completion.
- R10: With notification enabled but both `cfg_irq_en` and `cfg_wb_en` clear, a completion produces no output, and the channel accepts a new header in the next cycle.
- R11: `hdr_valid` is ignored unless the channel is idle, and `done_valid` is ignored unless a header is awaiting completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_notify_en | input | 1 | Channel notification-type enable |
| cfg_irq_en | input | 1 | Channel done-interrupt enable |
| cfg_wb_en | input | 1 | Channel done-writeback enable |
| hdr_valid | input | 1 | Header decode strobe |
| hdr_done_req | input | 1 | Header done-request bit |
| hdr_dir | input | 1 | Header direction bit |
| hdr_type | input | TYPE_W | Header descriptor type |
| hdr_pri_sel | input | SEL_W | Primary unit select |
| hdr_sec_sel | input | SEL_W | Secondary unit select |
| fetch_tag | input | TAG_W | Host tag from the fetch request |
| done_valid | input | 1 | Descriptor processing complete |
| pri_icv | input | 2 | Primary integrity-check code |
| sec_icv | input | 2 | Secondary integrity-check code |
| wb_ready | input | 1 | Bus master accepts writeback |
| wb_valid | output | 1 | Writeback request |
| wb_data | output | 64 | Writeback header dword |
| done_irq | output | 1 | Done interrupt pulse |
| err_irq | output | 1 | Header error interrupt pulse |
| hdr_err | output | 1 | Latched unrecognized-header error |
| seq_dir | output | 1 | Direction passed to sequencing |
| seq_type | output | TYPE_W | Descriptor type passed to sequencing |

## Verification
Every output is registered. Header fields and the error flag are therefore due one cycle after the decode strobe, and `wb_valid` is due one cycle after completion. `done_irq` is due one cycle after the accepting `wb_ready` cycle, or one cycle after completion when there is no writeback. The bench drives inputs on the falling edge. A behavioural model updated on each rising edge predicts every output, and the outputs are compared on the following falling edge. Held-ready stretches, disabled paths and ignored strobes are also checked through counts of accepted writes and interrupt pulses taken over each scenario.

// File: rtl/cn_pkg.sv
package cn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2,
    ST_ERR  = 2'd3
  } cn_state_e;

  localparam int WB_W       = 64;
  localparam int ICV_W      = 2;
  localparam logic [7:0] DONE_MARK = 8'hFF;
  localparam logic [ICV_W-1:0] ICV_NONE = 2'b00;
endpackage

// File: rtl/cn_hdr_check.sv
module cn_hdr_check #(
  parameter int SEL_W     = 4,
  parameter int NUM_UNITS = 8
) (
  input  logic [SEL_W-1:0] sel,
  output logic             sel_ok
);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_UNITS);

  always_comb begin
    sel_ok = (sel != '0) && (sel <= MAX_SEL);
  end
endmodule

// File: rtl/cn_wb_pack.sv
module cn_wb_pack
  import cn_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [ICV_W-1:0] pri_icv,
  input  logic [ICV_W-1:0] sec_icv,
  input  logic             sec_none,
  output logic [WB_W-1:0]  word
);
  localparam int TAG_LO = WB_W - 8 - TAG_W;
  localparam int PRI_LO = TAG_LO - ICV_W;
  localparam int SEC_LO = PRI_LO - ICV_W;

  always_comb begin
    word                     = '0;
    word[WB_W-1 -: 8]        = DONE_MARK;
    word[TAG_LO +: TAG_W]    = tag;
    word[PRI_LO +: ICV_W]    = pri_icv;
    word[SEC_LO +: ICV_W]    = sec_none ? ICV_NONE : sec_icv;
  end
endmodule

// File: rtl/cn_ctrl.sv
module cn_ctrl
  import cn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_valid,
  input  logic pri_ok,
  input  logic done_valid,
  input  logic done_req_q,
  input  logic cfg_notify_en,
  input  logic cfg_irq_en,
  input  logic cfg_wb_en,
  input  logic wb_ready,
  output logic hdr_load,
  output logic wb_load,
  output logic wb_valid,
  output logic done_irq,
  output logic err_irq,
  output logic hdr_err
);
  cn_state_e st_q, st_n;
  logic irq_pend_q, irq_pend_n;
  logic wbv_q, wbv_n;
  logic irq_q, irq_n;
  logic eirq_q, eirq_n;
  logic err_q, err_n;

  always_comb begin
    st_n       = st_q;
    irq_pend_n = irq_pend_q;
    wbv_n      = wbv_q;
    irq_n      = 1'b0;
    eirq_n     = 1'b0;
    err_n      = err_q;
    hdr_load   = 1'b0;
    wb_load    = 1'b0;
    case (st_q)
      ST_IDLE: if (hdr_valid) begin
        hdr_load = 1'b1;
        if (!pri_ok) begin
          err_n  = 1'b1;
          eirq_n = 1'b1;
          st_n   = ST_ERR;
        end else begin
          st_n = ST_RUN;
        end
      end
      ST_RUN: if (done_valid) begin
        st_n = ST_IDLE;
        if (done_req_q && cfg_notify_en) begin
          if (cfg_wb_en) begin
            wb_load    = 1'b1;
            wbv_n      = 1'b1;
            irq_pend_n = cfg_irq_en;
            st_n       = ST_WB;
          end else begin
            irq_n = cfg_irq_en;
          end
        end
      end
      ST_WB: if (wb_ready) begin
        wbv_n = 1'b0;
        irq_n = irq_pend_q;
        st_n  = ST_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      irq_pend_q <= 1'b0;
      wbv_q      <= 1'b0;
      irq_q      <= 1'b0;
      eirq_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_n;
      irq_pend_q <= irq_pend_n;
      wbv_q      <= wbv_n;
      irq_q      <= irq_n;
      eirq_q     <= eirq_n;
      err_q      <= err_n;
    end
  end

  assign wb_valid = wbv_q;
  assign done_irq = irq_q;
  assign err_irq  = eirq_q;
  assign hdr_err  = err_q;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R8
  AST_IRQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && irq_pend_q |=> done_irq); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> hdr_err); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq); // R3
  AST_NO_WB_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !wb_valid && !done_irq); // R3
endmodule

// File: rtl/cn_notify_unit.sv
module cn_notify_unit
  import cn_pkg::*;
#(
  parameter int TYPE_W    = 5,
  parameter int SEL_W     = 4,
  parameter int TAG_W     = 8,
  parameter int NUM_UNITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_notify_en,
  input  logic              cfg_irq_en,
  input  logic              cfg_wb_en,
  input  logic              hdr_valid,
  input  logic              hdr_done_req,
  input  logic              hdr_dir,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [SEL_W-1:0]  hdr_pri_sel,
  input  logic [SEL_W-1:0]  hdr_sec_sel,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic              done_valid,
  input  logic [1:0]        pri_icv,
  input  logic [1:0]        sec_icv,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [63:0]       wb_data,
  output logic              done_irq,
  output logic              err_irq,
  output logic              hdr_err,
  output logic              seq_dir,
  output logic [TYPE_W-1:0] seq_type
);
  logic pri_ok, hdr_load, wb_load;
  logic dir_q, dir_n;
  logic [TYPE_W-1:0] type_q, type_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic secnone_q, secnone_n;
  logic dreq_q, dreq_n;
  logic [WB_W-1:0] word, wbd_q, wbd_n;

  cn_hdr_check #(.SEL_W(SEL_W), .NUM_UNITS(NUM_UNITS)) u_check (
    .sel(hdr_pri_sel), .sel_ok(pri_ok));

  cn_wb_pack #(.TAG_W(TAG_W)) u_pack (
    .tag(tag_q), .pri_icv(pri_icv), .sec_icv(sec_icv),
    .sec_none(secnone_q), .word(word));

  cn_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .pri_ok(pri_ok),
    .done_valid(done_valid), .done_req_q(dreq_q),
    .cfg_notify_en(cfg_notify_en), .cfg_irq_en(cfg_irq_en),
    .cfg_wb_en(cfg_wb_en), .wb_ready(wb_ready), .hdr_load(hdr_load),
    .wb_load(wb_load), .wb_valid(wb_valid), .done_irq(done_irq),
    .err_irq(err_irq), .hdr_err(hdr_err));

  always_comb begin
    dir_n     = hdr_load ? hdr_dir : dir_q;
    type_n    = hdr_load ? hdr_type : type_q;
    tag_n     = hdr_load ? fetch_tag : tag_q;
    secnone_n = hdr_load ? (hdr_sec_sel == '0) : secnone_q;
    dreq_n    = hdr_load ? hdr_done_req : dreq_q;
    wbd_n     = wb_load ? word : wbd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= 1'b0;
      type_q    <= '0;
      tag_q     <= '0;
      secnone_q <= 1'b0;
      dreq_q    <= 1'b0;
      wbd_q     <= '0;
    end else begin
      dir_q     <= dir_n;
      type_q    <= type_n;
      tag_q     <= tag_n;
      secnone_q <= secnone_n;
      dreq_q    <= dreq_n;
      wbd_q     <= wbd_n;
    end
  end

  assign seq_dir  = dir_q;
  assign seq_type = type_q;
  assign wb_data  = wbd_q;

  AST_WB_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> $stable(wb_data)); // R5
  AST_DONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[63:56] == 8'hFF); // R6
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> $stable(seq_dir) && $stable(seq_type)); // R2
endmodule

// File: tb/cn_notify_unit_test.sv
module cn_notify_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_notify_en = 0, cfg_irq_en = 0, cfg_wb_en = 0;
  logic hdr_valid = 0, hdr_done_req = 0, hdr_dir = 0;
  logic [4:0] hdr_type = 0;
  logic [3:0] hdr_pri_sel = 0, hdr_sec_sel = 0;
  logic [7:0] fetch_tag = 0;
  logic done_valid = 0;
  logic [1:0] pri_icv = 0, sec_icv = 0;
  logic wb_ready = 0;
  logic wb_valid, done_irq, err_irq, hdr_err, seq_dir;
  logic [63:0] wb_data;
  logic [4:0] seq_type;

  int tests = 0, fails = 0, cycles = 0;
  int acc_cnt = 0, irq_cnt = 0;

  // behavioural model: 0 idle, 1 awaiting done, 2 writeback, 3 error
  int m_st = 0;
  bit m_dir, m_sec_none, m_dreq, m_err, m_eirq, m_wbv, m_irq, m_pend;
  bit [4:0] m_type;
  bit [7:0] m_tag;
  bit [63:0] m_wbd;

  always #4 clk = ~clk;

  cn_notify_unit uut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_dir = 0; m_type = 0; m_tag = 0; m_sec_none = 0;
      m_dreq = 0; m_err = 0; m_eirq = 0; m_wbv = 0; m_irq = 0; m_pend = 0;
      m_wbd = 0;
    end else begin
      if (wb_valid && wb_ready) acc_cnt++;
      m_eirq = 0;
      m_irq = 0;
      if (m_st == 0) begin
        if (hdr_valid) begin
          m_dir = hdr_dir; m_type = hdr_type; m_tag = fetch_tag;
          m_sec_none = (hdr_sec_sel == 0); m_dreq = hdr_done_req;
          if (hdr_pri_sel == 0 || hdr_pri_sel > 8) begin
            m_err = 1; m_eirq = 1; m_st = 3;
          end else m_st = 1;
        end
      end else if (m_st == 1) begin
        if (done_valid) begin
          m_st = 0;
          if (m_dreq && cfg_notify_en) begin
            if (cfg_wb_en) begin
              m_wbv = 1; m_pend = cfg_irq_en; m_st = 2;
              m_wbd = {8'hFF, m_tag, pri_icv, m_sec_none ? 2'b00 : sec_icv, 44'h0};
            end else m_irq = cfg_irq_en;
          end
        end
      end else if (m_st == 2) begin
        if (wb_ready) begin
          m_wbv = 0; m_irq = m_pend; m_st = 0;
        end
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_irq) irq_cnt++;
      chk("R2 seq_dir", 64'(seq_dir), 64'(m_dir));
      chk("R2 seq_type", 64'(seq_type), 64'(m_type));
      chk("R3 hdr_err", 64'(hdr_err), 64'(m_err));
      chk("R3 err_irq", 64'(err_irq), 64'(m_eirq));
      chk("R5 wb_valid", 64'(wb_valid), 64'(m_wbv));
      if (m_wbv) chk("R6 wb_data", wb_data, m_wbd);
      chk("R8 or R9 done_irq", 64'(done_irq), 64'(m_irq));
    end
  end

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_hdr(bit dreq, bit dir, bit [4:0] typ, bit [3:0] ps,
                          bit [3:0] ss, bit [7:0] tag);
    @(negedge clk);
    hdr_valid = 1; hdr_done_req = dreq; hdr_dir = dir; hdr_type = typ;
    hdr_pri_sel = ps; hdr_sec_sel = ss; fetch_tag = tag;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic send_done(bit [1:0] p, bit [1:0] s);
    @(negedge clk);
    done_valid = 1; pri_icv = p; sec_icv = s;
    @(negedge clk);
    done_valid = 0;
  endtask

  task automatic set_cfg(bit n, bit i, bit w);
    cfg_notify_en = n; cfg_irq_en = i; cfg_wb_en = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_cycles(3);
    rst_n = 1;
  endtask

  initial begin
    int a0, i0;
    idle_cycles(3);
    chk("R1 wb_valid in reset", 64'(wb_valid), 0);
    chk("R1 done_irq in reset", 64'(done_irq), 0);
    chk("R1 hdr_err in reset", 64'(hdr_err), 0);
    rst_n = 1;
    idle_cycles(2);
    chk("R1 err_irq after reset", 64'(err_irq), 0);
    chk("R1 seq_type after reset", 64'(seq_type), 0);

    // writeback plus interrupt, ready delayed
    set_cfg(1, 1, 1);
    a0 = acc_cnt; i0 = irq_cnt;
    send_hdr(1, 1, 5'd9, 4'd3, 4'd5, 8'hA5);
    send_done(2'b01, 2'b10);
    idle_cycles(3);
    chk("R5 valid held without ready", 64'(wb_valid), 1);
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    chk("R6 word layout", wb_data, {8'hFF, 8'hA5, 2'b01, 2'b10, 44'h0});
    idle_cycles(2);
    chk("R8 one write one irq", 64'(acc_cnt - a0 + irq_cnt - i0), 2);

    // writeback only, secondary unit not selected
    set_cfg(1, 0, 1);
    wb_ready = 1;
    a0 = acc_cnt; i0 = irq_cnt;
    send_hdr(1, 0, 5'd2, 4'd8, 4'd0, 8'h3C);
    send_done(2'b10, 2'b11);
    chk("R7 sec field forced 00", 64'(wb_data[45:44]), 0);
    chk("R7 pri failed code", 64'(wb_data[47:46]), 2);
    idle_cycles(2);
    chk("R8 no irq when disabled", 64'(irq_cnt - i0), 0);
    chk("R5 one write accepted", 64'(acc_cnt - a0), 1);

    // reserved code passes through
    send_hdr(1, 1, 5'd1, 4'd1, 4'd2, 8'h11);
    send_done(2'b11, 2'b00);
    chk("R7 reserved code", 64'(wb_data[47:44]), 64'(4'b1100));
    idle_cycles(2);

    // interrupt only
    set_cfg(1, 1, 0);
    a0 = acc_cnt; i0 = irq_cnt;
    send_hdr(1, 0, 5'd4, 4'd2, 4'd0, 8'h01);
    send_done(2'b01, 2'b01);
    idle_cycles(2);
    chk("R9 irq without write", 64'(irq_cnt - i0), 1);
    chk("R9 no write", 64'(acc_cnt - a0), 0);

    // done bit clear, then notify disabled
    set_cfg(1, 1, 1);
    a0 = acc_cnt; i0 = irq_cnt;
    send_hdr(0, 1, 5'd7, 4'd2, 4'd1, 8'h22);
    send_done(2'b01, 2'b01);
    set_cfg(0, 1, 1);
    send_hdr(1, 1, 5'd7, 4'd2, 4'd1, 8'h23);
    send_done(2'b01, 2'b01);
    idle_cycles(3);
    chk("R4 no output when not requested", 64'(acc_cnt - a0 + irq_cnt - i0), 0);

    // both forms disabled
    set_cfg(1, 0, 0);
    send_hdr(1, 0, 5'd3, 4'd2, 4'd1, 8'h24);
    send_done(2'b01, 2'b01);
    send_hdr(1, 1, 5'd6, 4'd2, 4'd1, 8'h25);
    chk("R10 new header taken", 64'(seq_type), 6);
    chk("R10 nothing emitted", 64'(acc_cnt - a0 + irq_cnt - i0), 0);

    // ignored strobes
    send_hdr(1, 0, 5'd12, 4'd2, 4'd1, 8'h26);
    chk("R11 header ignored while busy", 64'(seq_type), 6);
    send_done(2'b00, 2'b00);
    send_done(2'b00, 2'b00);
    send_hdr(1, 0, 5'd13, 4'd2, 4'd1, 8'h27);
    chk("R11 idle after done", 64'(seq_type), 13);

    // header errors
    set_cfg(1, 1, 1);
    do_reset();
    i0 = irq_cnt; a0 = acc_cnt;
    send_hdr(1, 0, 5'd1, 4'd0, 4'd1, 8'h30);
    chk("R3 error latched for no unit", 64'(hdr_err), 1);
    send_done(2'b01, 2'b01);
    send_hdr(1, 1, 5'd2, 4'd2, 4'd1, 8'h31);
    idle_cycles(2);
    chk("R3 error sticky", 64'(hdr_err), 1);
    chk("R3 nothing after error", 64'(acc_cnt - a0 + irq_cnt - i0), 0);
    do_reset();
    chk("R3 cleared by reset", 64'(hdr_err), 0);
    send_hdr(1, 0, 5'd1, 4'd9, 4'd1, 8'h32);
    chk("R3 reserved select", 64'(hdr_err), 1);
    do_reset();
    send_hdr(1, 0, 5'd1, 4'd8, 4'd1, 8'h33);
    chk("R3 top select legal", 64'(hdr_err), 0);
    idle_cycles(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule